// File: doc/BRIEF.md
# Memory-Mapped I/O Range Router with Per-Pair Lock

This block decides where a memory-mapped I/O request goes. It holds eight window pairs. Each pair has a start register and an end register, and both registers cover address bits 39 to 16 of a 40-bit request address. For every valid request, the block finds the first window that accepts the request and returns that window's destination node, destination link and non-posted attribute. The answer appears one clock after the request.

Software programs the windows through a configuration port. Each write carries a per-bit write mask. A window can be frozen with a lock bit. Once the lock bit is set, neither register of that pair can be changed until the next reset. A window can also refuse requests that come from the CPU while still serving other requesters. Each window gates reads and writes separately.

Top module: `mmio_router`

## Requirements
- R1: Reset clears every start and end register to zero. After reset every request gets rsp_valid=1 with rsp_hit=0 and rsp_err=0.
- R2: A configuration write changes only the bits whose wr_mask bit is 1. cfg_sel=0 selects the start register and cfg_sel=1 selects the end register of the pair named by cfg_idx. The storable bits are as follows. Start register: bits 31:8 and 3:0. End register: bits 31:8, bit 7, bits 5:4 and bits 2:0. All other bits always read back as 0 on cfg_rdata.
- R3: Start register bit 3 is the lock bit. While it is 1, writes to both registers of that pair have no effect. Only reset can clear it.
- R4: A pair covers a request when start[31:8] <= req_addr[39:16] <= end[31:8]. Both bounds are inclusive. rsp_valid and the other response outputs reflect a request one cycle after req_valid.
- R5: Start register bit 0 lets the pair serve reads (req_write=0). Start register bit 1 lets it serve writes (req_write=1).
- R6: When start register bit 2 is 1, the pair ignores requests with req_cpu=1 but still serves requests with req_cpu=0.
- R7: When several pairs accept a request, the pair with the lowest index wins.
- R8: On a hit, rsp_node is end register bits 2:0 and rsp_link is end register bits 5:4.
- R9: If the winning pair's link code is 3, the response has rsp_err=1, rsp_hit=0, and node and link both 0.
- R10: rsp_nonposted is 1 only on a hit for a CPU write where end register bit 7 is 1.
- R11: If no pair accepts a request, the response has hit, err, node, link and nonposted all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Pair index for write and readback |
| cfg_sel | input | 1 | 0 selects the start register, 1 selects the end register |
| cfg_wdata | input | 32 | Write data |
| cfg_wmask | input | 32 | Per-bit write mask |
| cfg_rdata | output | 32 | Combinational readback of the selected register |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 40 | Request address |
| req_write | input | 1 | 1 for a write request, 0 for a read request |
| req_cpu | input | 1 | 1 when the requester is the CPU |
| rsp_valid | output | 1 | Response present, one cycle after req_valid |
| rsp_hit | output | 1 | A usable route was found |
| rsp_err | output | 1 | The winning pair has a reserved link code |
| rsp_node | output | 3 | Destination node |
| rsp_link | output | 2 | Destination link |
| rsp_nonposted | output | 1 | The CPU write must be sent as non-posted |

## Verification
The assertions assume that rst_n is held low for at least one clock before the first request. They also assume that the configuration inputs and request inputs settle well before each rising edge. The bench keeps to both: it holds reset for several cycles and waits for the internal synchroniser to release. It changes every input 2 ns after a rising edge. Configuration writes and requests may fall in the same cycle. The response is defined to use the register contents from before that edge, and the bench's random phase exercises that overlap.

// File: rtl/mmio_router_pkg.sv
package mmio_router_pkg;
  localparam int ADDR_W   = 40;
  localparam int PAGE_LSB = 16;
  localparam int PAGE_W   = ADDR_W - PAGE_LSB;
  localparam int REG_W    = 32;
  localparam int FLD_LSB  = 8;

  // start register control bits
  localparam int B_RD   = 0;
  localparam int B_WR   = 1;
  localparam int B_NCPU = 2;
  localparam int B_LOCK = 3;
  // end register attribute bits
  localparam int L_NP   = 7;

  localparam logic [REG_W-1:0] START_KEEP = 32'hFFFF_FF0F;
  localparam logic [REG_W-1:0] END_KEEP   = 32'hFFFF_FFB7;

  typedef logic [REG_W-1:0] word_t;
  typedef logic [PAGE_W-1:0] page_t;
endpackage

// File: rtl/mmio_region.sv
module mmio_region
  import mmio_router_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  logic  wr_sel,
  input  word_t wr_data,
  input  word_t wr_mask,
  input  page_t req_page,
  input  logic  req_write,
  input  logic  req_cpu,
  output word_t start_q,
  output word_t end_q,
  output logic  accept
);
  word_t start_d, end_d;
  logic  upd;
  logic  frozen;
  logic  in_range, kind_ok, src_ok;

  assign frozen = start_q[B_LOCK];
  assign upd    = wr_en && !frozen;

  always_comb begin
    start_d = start_q;
    end_d   = end_q;
    if (wr_sel) end_d   = ((end_q   & ~wr_mask) | (wr_data & wr_mask)) & END_KEEP;
    else        start_d = ((start_q & ~wr_mask) | (wr_data & wr_mask)) & START_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
    end else if (upd) begin
      start_q <= start_d;
      end_q   <= end_d;
    end
  end

  always_comb begin
    in_range = (start_q[REG_W-1:FLD_LSB] <= req_page) && (req_page <= end_q[REG_W-1:FLD_LSB]);
    kind_ok  = req_write ? start_q[B_WR] : start_q[B_RD];
    src_ok   = !(req_cpu && start_q[B_NCPU]);
    accept   = in_range && kind_ok && src_ok;
  end
endmodule

// File: rtl/mmio_pick.sv
module mmio_pick #(
  parameter int N     = 8,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_vec,
  output logic          any,
  output logic [IW-1:0] sel
);
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_vec[i]) begin
        any = 1'b1;
        sel = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mmio_router.sv
module mmio_router
  import mmio_router_pkg::*;
#(
  parameter int N_PAIRS = 8,
  localparam int IW     = (N_PAIRS > 1) ? $clog2(N_PAIRS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IW-1:0]     cfg_idx,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic [31:0]       cfg_wmask,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_cpu,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_err,
  output logic [2:0]        rsp_node,
  output logic [1:0]        rsp_link,
  output logic              rsp_nonposted
);
  logic rst_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  word_t [N_PAIRS-1:0] start_all, end_all;
  logic  [N_PAIRS-1:0] accept_vec;
  page_t               page;
  assign page = req_addr[ADDR_W-1:PAGE_LSB];

  for (genvar g = 0; g < N_PAIRS; g++) begin : g_pair
    mmio_region u_reg (
      .clk       (clk),
      .rst_n     (rst_sn),
      .wr_en     (cfg_we && (cfg_idx == IW'(g))),
      .wr_sel    (cfg_sel),
      .wr_data   (cfg_wdata),
      .wr_mask   (cfg_wmask),
      .req_page  (page),
      .req_write (req_write),
      .req_cpu   (req_cpu),
      .start_q   (start_all[g]),
      .end_q     (end_all[g]),
      .accept    (accept_vec[g])
    );
  end

  assign cfg_rdata = cfg_sel ? end_all[cfg_idx] : start_all[cfg_idx];

  logic          any;
  logic [IW-1:0] win;
  mmio_pick #(.N(N_PAIRS)) u_pick (.req_vec(accept_vec), .any(any), .sel(win));

  word_t      win_end;
  logic       valid_d, hit_d, err_d, np_d;
  logic [2:0] node_d;
  logic [1:0] link_d;

  always_comb begin
    win_end = end_all[win];
    valid_d = req_valid;
    hit_d   = req_valid && any && (win_end[5:4] != 2'b11);
    err_d   = req_valid && any && (win_end[5:4] == 2'b11);
    node_d  = hit_d ? win_end[2:0] : 3'd0;
    link_d  = hit_d ? win_end[5:4] : 2'd0;
    np_d    = hit_d && req_write && req_cpu && win_end[L_NP];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_err       <= 1'b0;
      rsp_node      <= '0;
      rsp_link      <= '0;
      rsp_nonposted <= 1'b0;
    end else begin
      rsp_valid     <= valid_d;
      rsp_hit       <= hit_d;
      rsp_err       <= err_d;
      rsp_node      <= node_d;
      rsp_link      <= link_d;
      rsp_nonposted <= np_d;
    end
  end
endmodule

// File: rtl/mmio_router_chk.sv
module mmio_router_chk #(
  parameter int N = 8
) (
  input logic                   clk,
  input logic                   rst_sn,
  input logic                   req_valid,
  input logic                   rsp_valid,
  input logic                   rsp_hit,
  input logic                   rsp_err,
  input logic [1:0]             rsp_link,
  input logic                   rsp_nonposted,
  input logic [N-1:0][31:0]     start_all,
  input logic [N-1:0][31:0]     end_all
);
  a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_sn)
    req_valid |=> rsp_valid);
  a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_sn)
    !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_err && !rsp_nonposted));
  a_r9_hit_err_exclusive: assert property (@(posedge clk) disable iff (!rst_sn)
    !(rsp_hit && rsp_err));
  a_r9_no_reserved_route: assert property (@(posedge clk) disable iff (!rst_sn)
    rsp_hit |-> rsp_link != 2'b11);
  a_r10_np_needs_hit: assert property (@(posedge clk) disable iff (!rst_sn)
    rsp_nonposted |-> rsp_hit);

  for (genvar g = 0; g < N; g++) begin : g_lock
    a_r3_lock_freezes: assert property (@(posedge clk) disable iff (!rst_sn)
      start_all[g][3] |=> ($stable(start_all[g]) && $stable(end_all[g])));
  end
endmodule

bind mmio_router mmio_router_chk #(.N(N_PAIRS)) u_chk (
  .clk           (clk),
  .rst_sn        (rst_sn),
  .req_valid     (req_valid),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .rsp_err       (rsp_err),
  .rsp_link      (rsp_link),
  .rsp_nonposted (rsp_nonposted),
  .start_all     (start_all),
  .end_all       (end_all)
);

// File: tb/sim_mmio_router.sv
`timescale 1ns/1ps
module sim_mmio_router;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_idx = 0;
  logic        cfg_sel = 0;
  logic [31:0] cfg_wdata = 0, cfg_wmask = 0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 0;
  logic [39:0] req_addr = 0;
  logic        req_write = 0, req_cpu = 0;
  logic        rsp_valid, rsp_hit, rsp_err, rsp_nonposted;
  logic [2:0]  rsp_node;
  logic [1:0]  rsp_link;

  always #5 clk = ~clk;

  mmio_router u0 (.*);

  int    errors = 0, checks = 0;
  string phase = "R1 reset";
  bit    compare_on = 0;

  // behavioural reference
  logic [31:0] m_start [8];
  logic [31:0] m_end   [8];
  logic        e_valid, e_hit, e_err, e_np;
  logic [2:0]  e_node;
  logic [1:0]  e_link;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_start[i] = 0; m_end[i] = 0; end
      {e_valid, e_hit, e_err, e_np, e_node, e_link} = '0;
    end else begin
      int w;
      w = -1;
      for (int i = 0; i < 8; i++) begin
        int pg;
        bit ok;
        pg = int'(req_addr[39:16]);
        ok = (int'(m_start[i][31:8]) <= pg) && (pg <= int'(m_end[i][31:8]));
        ok = ok && (req_write ? m_start[i][1] : m_start[i][0]);
        if (req_cpu && m_start[i][2]) ok = 0;
        if (ok && w < 0) w = i;
      end
      e_valid = req_valid;
      e_hit = 0; e_err = 0; e_np = 0; e_node = 0; e_link = 0;
      if (req_valid && w >= 0) begin
        if (m_end[w][5:4] == 2'b11) e_err = 1;
        else begin
          e_hit  = 1;
          e_node = m_end[w][2:0];
          e_link = m_end[w][5:4];
          e_np   = req_write && req_cpu && m_end[w][7];
        end
      end
      if (cfg_we && !m_start[cfg_idx][3]) begin
        if (cfg_sel)
          m_end[cfg_idx] = ((m_end[cfg_idx] & ~cfg_wmask) | (cfg_wdata & cfg_wmask)) & 32'hFFFF_FFB7;
        else
          m_start[cfg_idx] = ((m_start[cfg_idx] & ~cfg_wmask) | (cfg_wdata & cfg_wmask)) & 32'hFFFF_FF0F;
      end
    end
  end

  always @(negedge clk) if (compare_on) begin
    logic [31:0] e_rd;
    e_rd = cfg_sel ? m_end[cfg_idx] : m_start[cfg_idx];
    checks++;
    if ({rsp_valid, rsp_hit, rsp_err, rsp_node, rsp_link, rsp_nonposted} !==
        {e_valid, e_hit, e_err, e_node, e_link, e_np}) begin
      errors++;
      $display("FAIL %s: rsp v/h/e/node/link/np actual %b%b%b %0d %0d %b expected %b%b%b %0d %0d %b",
               phase, rsp_valid, rsp_hit, rsp_err, rsp_node, rsp_link, rsp_nonposted,
               e_valid, e_hit, e_err, e_node, e_link, e_np);
    end
    checks++;
    if (cfg_rdata !== e_rd) begin
      errors++;
      $display("FAIL %s: rdata actual %h expected %h", phase, cfg_rdata, e_rd);
    end
  end

  task automatic step_in();
    @(posedge clk); #2;
    cfg_we = 0; req_valid = 0;
  endtask

  task automatic wr(input int idx, input bit sel, input logic [31:0] d, input logic [31:0] m);
    step_in();
    cfg_we = 1; cfg_idx = 3'(idx); cfg_sel = sel; cfg_wdata = d; cfg_wmask = m;
  endtask

  task automatic rq(input logic [23:0] pg, input bit w, input bit cpu);
    step_in();
    req_valid = 1; req_addr = {pg, 16'h1234}; req_write = w; req_cpu = cpu;
  endtask

  task automatic peek(input int idx, input bit sel);
    step_in();
    cfg_idx = 3'(idx); cfg_sel = sel;
  endtask

  task automatic do_reset();
    compare_on = 0;
    step_in();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) @(posedge clk);
    compare_on = 1;
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    phase = "R1 reset";
    for (int i = 0; i < 8; i++) begin peek(i, 0); peek(i, 1); end
    rq(24'h000010, 0, 0); rq(24'h000000, 1, 1);

    phase = "R2 masked write";
    wr(7, 0, 32'hFFFF_FFF3, 32'h0000_FF07);
    peek(7, 0);
    wr(7, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    peek(7, 1);
    wr(7, 1, 32'h0000_0000, 32'hFF00_0000);
    peek(7, 1);
    wr(7, 0, 32'h0, 32'hFFFF_FFF7);
    wr(7, 1, 32'h0, 32'hFFFF_FFFF);

    phase = "R4 R8 range";
    wr(0, 0, 32'h0000_1003, '1);
    wr(0, 1, 32'h0000_1F15, '1);
    rq(24'h00000F, 0, 0); rq(24'h000010, 0, 0); rq(24'h00001F, 1, 1); rq(24'h000020, 0, 0);

    phase = "R5 read write gate";
    wr(1, 0, 32'h0000_2001, '1);
    wr(1, 1, 32'h0000_2F02, '1);
    rq(24'h000025, 0, 0); rq(24'h000025, 1, 0);

    phase = "R6 cpu disable";
    wr(2, 0, 32'h0000_3007, '1);
    wr(2, 1, 32'h0000_3F83, '1);
    rq(24'h000033, 1, 1); rq(24'h000033, 1, 0); rq(24'h000033, 0, 1);

    phase = "R10 nonposted";
    wr(3, 0, 32'h0000_4003, '1);
    wr(3, 1, 32'h0000_4F84, '1);
    rq(24'h000044, 1, 1); rq(24'h000044, 0, 1); rq(24'h000044, 1, 0);

    phase = "R7 priority";
    wr(4, 0, 32'h0000_1803, '1);
    wr(4, 1, 32'h0000_2F26, '1);
    rq(24'h000018, 0, 0); rq(24'h00001F, 1, 0); rq(24'h000020, 0, 1);

    phase = "R9 reserved link";
    wr(6, 0, 32'h0000_5003, '1);
    wr(6, 1, 32'h0000_5F31, '1);
    rq(24'h000055, 0, 0); rq(24'h000055, 1, 1);

    phase = "R11 miss";
    rq(24'hFFFFFF, 0, 0); rq(24'h000060, 1, 1);

    phase = "R3 lock";
    wr(3, 0, 32'h0000_0008, 32'h0000_0008);
    peek(3, 0);
    wr(3, 0, 32'h0, '1);
    wr(3, 1, 32'h0, '1);
    peek(3, 0); peek(3, 1);
    rq(24'h000044, 1, 1);
    wr(3, 0, 32'h0, 32'h0000_0008);
    peek(3, 0);
    wr(2, 0, 32'h0000_3003, '1);
    rq(24'h000033, 1, 1);

    phase = "R1 reset clears";
    do_reset();
    peek(3, 0); peek(3, 1); peek(0, 1);
    rq(24'h000044, 1, 1); rq(24'h000010, 0, 0);
    wr(3, 0, 32'h0000_4003, '1);
    peek(3, 0);

    phase = "R2-mix random";
    for (int k = 0; k < 600; k++) begin
      step_in();
      cfg_we    = ($urandom % 3) == 0;
      cfg_idx   = 3'($urandom);
      cfg_sel   = 1'($urandom);
      cfg_wdata = {8'h0, 8'($urandom % 128), 16'($urandom)};
      if (($urandom % 16) != 0) cfg_wdata[3] = 1'b0;
      cfg_wmask = (($urandom % 2) == 0) ? 32'hFFFF_FFFF : $urandom;
      req_valid = 1'($urandom);
      req_addr  = {8'h0, 8'($urandom % 128), 24'($urandom)};
      req_write = 1'($urandom);
      req_cpu   = 1'($urandom);
    end
    step_in();
    step_in();
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule